// File: doc/BRIEF.md
# Memory-to-Stream Read DMA Channel

This block fetches a programmed run of 32-bit words from memory and delivers them, in order, on a valid/ready output stream. Software places a 64-bit word-aligned start address in two address registers. It sets the control options, then writes a word count together with an end-of-message enable into the size register. That write starts the transfer. The channel sends single-word read requests on a simple request/response memory port. It parks each returned word in a 128-entry FIFO and drains the FIFO onto the stream.

Two independent pause bits let software freeze either side of the channel. One freezes the issue of new memory requests and the other freezes the stream output. Clearing a pause bit lets the transfer carry on from the point where it stopped. Every word returned from memory is added into a running 32-bit sum. Only an explicit clear resets that sum. An optional byte reversal is applied to each word on its way to the stream. A fixed-address mode re-reads the same location for every word. The number of reads in flight is capped by a programmable limit. A request is only issued once FIFO room is guaranteed for every reply still in flight.

Top module: `m2s_read_dma`

## Requirements
- R1: A write to the size register (index 2) with word count N = wdata[31:2] nonzero while idle starts a transfer. The transfer reads N words starting at {ADDR_HI, ADDR_LO with bits 1:0 forced to 0}, with the address rising by 4 per word. The returned words leave on the stream in request order. A size write while busy, or with N = 0, is ignored.
- R2: With the fixed-address control bit (CTRL bit 3) set, every read request of the transfer carries the start address.
- R3: With size-write bit 0 (last enable) set, st_last is high exactly on the beat of word N and on no other beat. With it clear, st_last never rises.
- R4: While the memory pause bit (CTRL bit 0) is 1, no read request is presented. Clearing it resumes the transfer where it stopped. Writing it to 0 when it is already 0 leaves the transfer unchanged.
- R5: While the stream pause bit (CTRL bit 1) is 1, st_valid stays low and fetched words stay queued. Clearing it resumes output with no word lost.
- R6: The checksum register (index 5) adds every returned memory word, before any byte reversal, modulo 2^32. It keeps its value across transfers. Any write to index 5 clears it, and a word returned in the same cycle as the clear is still counted.
- R7: At most M+1 reads are in flight, where M = CTRL bits 7:4. A written value above 8 is taken as 8.
- R8: A read is issued only while the number of reads in flight plus the FIFO occupancy is below 128. A stalled stream therefore lets exactly 128 reads through.
- R9: busy (and STATUS bit 0, index 4) is high from the accepted size write until the final beat is accepted on the stream. done is high for the single cycle after that beat, and busy falls on the same edge.
- R10: With the swap control bit (CTRL bit 2) set, the byte order of each stream word is reversed. With it clear, words pass unchanged.
- R11: While busy, the address registers (index 0 low, index 1 high) read the next request address. The size register reads {remaining words in bits 31:2, last enable in bit 0}, where remaining counts words not yet accepted on the stream.
- R12: After reset the channel is idle with no request, no stream beat, no done pulse, and the size, status, control and checksum registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mreq_valid | output | 1 | Read request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_addr | output | 64 | Read request byte address |
| mrsp_valid | input | 1 | Read response valid (always accepted) |
| mrsp_data | input | 32 | Read response word |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Stream consumer ready |
| st_data | output | 32 | Stream word |
| st_last | output | 1 | Final word of the message |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The channel is driven with transfers that vary in length (1 to 200 words), in in-flight limit, in address mode and in byte order. One start address has nonzero low bits and one crosses a 4 GiB boundary. The memory answers with a 12-cycle latency, so the limit on reads in flight shows as the peak count. Memory and stream readiness are switched between always-ready and toggling patterns. The toggling patterns separate ordering and backpressure faults from plain data faults. Directed runs pause each side of the channel and check the exact 128-read stall, the readback registers, size writes made while busy, a zero-length start, and checksum accumulation and clearing.

// File: rtl/m2s_dma_pkg.sv
package m2s_dma_pkg;

    localparam int WORD_W = 32;
    localparam int REG_AW = 3;

    // register indices
    typedef enum logic [REG_AW-1:0] {
        RA_ADDR_LO = 3'd0,
        RA_ADDR_HI = 3'd1,
        RA_SIZE    = 3'd2,
        RA_CTRL    = 3'd3,
        RA_STATUS  = 3'd4,
        RA_CSUM    = 3'd5
    } reg_idx_e;

    // control register bit positions
    localparam int CB_MEM_PAUSE  = 0;
    localparam int CB_STRM_PAUSE = 1;
    localparam int CB_SWAP       = 2;
    localparam int CB_FIXED      = 3;
    localparam int CB_MO_LSB     = 4;

    // size register bit positions
    localparam int SB_LAST     = 0;
    localparam int SB_WORD_LSB = 2;

endpackage

// File: rtl/m2s_dma_fifo.sv
module m2s_dma_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 128,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LVL_W-1:0] level,
    output logic             empty
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t f_q, f_d;
    logic [WIDTH-1:0] store [DEPTH];

    always_comb begin
        f_d = f_q;
        if (push) f_d.wr = f_q.wr + PTR_W'(1);
        if (pop)  f_d.rd = f_q.rd + PTR_W'(1);
        f_d.lvl = f_q.lvl + LVL_W'(push) - LVL_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push) store[f_q.wr] <= din;
    end

    assign dout  = store[f_q.rd];
    assign level = f_q.lvl;
    assign empty = (f_q.lvl == '0);

endmodule

// File: rtl/m2s_dma_issue.sv
module m2s_dma_issue #(
    parameter int ADDR_W  = 64,
    parameter int SIZE_W  = 30,
    parameter int DEPTH   = 128,
    parameter int MAX_OUT = 8,
    parameter int OUT_W   = $clog2(MAX_OUT + 2),
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [SIZE_W-1:0] start_words,
    input  logic              fixed_addr,
    input  logic [OUT_W-1:0]  max_out,
    input  logic              mem_pause,
    input  logic [LVL_W-1:0]  fifo_level,
    input  logic              rsp_valid,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [OUT_W-1:0]  outst
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] left;
        logic [OUT_W-1:0]  outst;
    } iss_st_t;

    iss_st_t s_q, s_d;
    logic [LVL_W:0] claimed;
    logic           fire;

    always_comb begin
        // room is held back for every reply still in flight
        claimed   = (LVL_W+1)'(fifo_level) + (LVL_W+1)'(s_q.outst);
        req_valid = (s_q.left != '0) && !mem_pause
                    && (s_q.outst <= max_out)
                    && (claimed < (LVL_W+1)'(DEPTH));
        fire      = req_valid && req_ready;

        s_d = s_q;
        if (start) begin
            s_d.addr = start_addr;
            s_d.left = start_words;
        end else if (fire) begin
            s_d.left = s_q.left - SIZE_W'(1);
            if (!fixed_addr) s_d.addr = s_q.addr + ADDR_W'(4);
        end
        s_d.outst = s_q.outst + OUT_W'(fire) - OUT_W'(rsp_valid);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign req_addr = s_q.addr;
    assign outst    = s_q.outst;

endmodule

// File: rtl/m2s_read_dma.sv
module m2s_read_dma
    import m2s_dma_pkg::*;
#(
    parameter int SIZE_W  = 30,
    parameter int DEPTH   = 128,
    parameter int MAX_OUT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [2*WORD_W-1:0] mreq_addr,
    input  logic              mrsp_valid,
    input  logic [WORD_W-1:0] mrsp_data,
    output logic              st_valid,
    input  logic              st_ready,
    output logic [WORD_W-1:0] st_data,
    output logic              st_last,
    output logic              busy,
    output logic              done
);

    localparam int ADDR_W = 2 * WORD_W;
    localparam int OUT_W  = $clog2(MAX_OUT + 2);
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int BYTES  = WORD_W / 8;

    typedef struct packed {
        logic [WORD_W-1:0] addr_lo;
        logic [WORD_W-1:0] addr_hi;
        logic              mem_pause;
        logic              strm_pause;
        logic              swap;
        logic              fixed_addr;
        logic [OUT_W-1:0]  max_out;
        logic [SIZE_W-1:0] remaining;
        logic              last_en;
        logic              busy;
        logic              done;
        logic [WORD_W-1:0] csum;
    } top_st_t;

    top_st_t s_q, s_d;

    logic              start;
    logic              csum_clr;
    logic              pop;
    logic [OUT_W-1:0]  mo_in;
    logic [WORD_W-1:0] fifo_head;
    logic [WORD_W-1:0] head_rev;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_empty;
    logic [OUT_W-1:0]  issue_outst;
    logic              mem_pause_w;
    logic              strm_pause_w;

    // ---------------- next-state logic ----------------
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        start    = 1'b0;
        csum_clr = 1'b0;
        mo_in    = reg_wdata[CB_MO_LSB +: OUT_W];
        if (mo_in > OUT_W'(MAX_OUT)) mo_in = OUT_W'(MAX_OUT);

        if (reg_we) begin
            case (reg_idx_e'(reg_addr))
                RA_ADDR_LO: s_d.addr_lo = {reg_wdata[WORD_W-1:2], 2'b00};
                RA_ADDR_HI: s_d.addr_hi = reg_wdata;
                RA_SIZE: begin
                    if (!s_q.busy && (reg_wdata[SB_WORD_LSB +: SIZE_W] != '0)) begin
                        start         = 1'b1;
                        s_d.remaining = reg_wdata[SB_WORD_LSB +: SIZE_W];
                        s_d.last_en   = reg_wdata[SB_LAST];
                        s_d.busy      = 1'b1;
                    end
                end
                RA_CTRL: begin
                    s_d.mem_pause  = reg_wdata[CB_MEM_PAUSE];
                    s_d.strm_pause = reg_wdata[CB_STRM_PAUSE];
                    s_d.swap       = reg_wdata[CB_SWAP];
                    s_d.fixed_addr = reg_wdata[CB_FIXED];
                    s_d.max_out    = mo_in;
                end
                RA_CSUM: csum_clr = 1'b1;
                default: ;
            endcase
        end

        // stream side: one beat leaves per accepted handshake
        if (pop) begin
            s_d.remaining = s_q.remaining - SIZE_W'(1);
            if (s_q.remaining == SIZE_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end

        s_d.csum = (csum_clr ? '0 : s_q.csum) + (mrsp_valid ? mrsp_data : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // ---------------- request issue ----------------
    m2s_dma_issue #(
        .ADDR_W  (ADDR_W),
        .SIZE_W  (SIZE_W),
        .DEPTH   (DEPTH),
        .MAX_OUT (MAX_OUT),
        .OUT_W   (OUT_W),
        .LVL_W   (LVL_W)
    ) i_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_addr  ({s_q.addr_hi, s_q.addr_lo}),
        .start_words (s_d.remaining),
        .fixed_addr  (s_q.fixed_addr),
        .max_out     (s_q.max_out),
        .mem_pause   (s_q.mem_pause),
        .fifo_level  (fifo_level),
        .rsp_valid   (mrsp_valid),
        .req_ready   (mreq_ready),
        .req_valid   (mreq_valid),
        .req_addr    (mreq_addr),
        .outst       (issue_outst)
    );

    // ---------------- word buffer ----------------
    m2s_dma_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH),
        .LVL_W (LVL_W)
    ) i_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (mrsp_valid),
        .din   (mrsp_data),
        .pop   (pop),
        .dout  (fifo_head),
        .level (fifo_level),
        .empty (fifo_empty)
    );

    // byte-lane reversal
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign head_rev[8*b +: 8] = fifo_head[8*(BYTES-1-b) +: 8];
    end

    // ---------------- stream output ----------------
    assign st_valid = s_q.busy && !fifo_empty && !s_q.strm_pause;
    assign pop      = st_valid && st_ready;
    assign st_data  = s_q.swap ? head_rev : fifo_head;
    assign st_last  = st_valid && s_q.last_en && (s_q.remaining == SIZE_W'(1));
    assign busy     = s_q.busy;
    assign done     = s_q.done;

    assign mem_pause_w  = s_q.mem_pause;
    assign strm_pause_w = s_q.strm_pause;

    // ---------------- register readback ----------------
    always_comb begin
        reg_rdata = '0;
        case (reg_idx_e'(reg_addr))
            RA_ADDR_LO: reg_rdata = s_q.busy ? mreq_addr[WORD_W-1:0] : s_q.addr_lo;
            RA_ADDR_HI: reg_rdata = s_q.busy ? mreq_addr[ADDR_W-1:WORD_W] : s_q.addr_hi;
            RA_SIZE: begin
                reg_rdata[SB_WORD_LSB +: SIZE_W] = s_q.remaining;
                reg_rdata[SB_LAST]               = s_q.last_en;
            end
            RA_CTRL: begin
                reg_rdata[CB_MEM_PAUSE]        = s_q.mem_pause;
                reg_rdata[CB_STRM_PAUSE]       = s_q.strm_pause;
                reg_rdata[CB_SWAP]             = s_q.swap;
                reg_rdata[CB_FIXED]            = s_q.fixed_addr;
                reg_rdata[CB_MO_LSB +: OUT_W]  = s_q.max_out;
            end
            RA_STATUS: reg_rdata[0] = s_q.busy;
            RA_CSUM:   reg_rdata = s_q.csum;
            default: ;
        endcase
    end

endmodule

// File: rtl/m2s_dma_checker.sv
module m2s_dma_checker #(
    parameter int DEPTH   = 128,
    parameter int MAX_OUT = 8,
    parameter int OUT_W   = $clog2(MAX_OUT + 2),
    parameter int LVL_W   = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mreq_valid,
    input logic             st_valid,
    input logic             st_last,
    input logic             busy,
    input logic             done,
    input logic             mem_pause,
    input logic             strm_pause,
    input logic [OUT_W-1:0] outst,
    input logic [LVL_W-1:0] fifo_level
);

    // R4: memory pause holds off all requests
    assert_mem_pause_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pause |-> !mreq_valid);

    // R5: stream pause holds off all beats
    assert_strm_pause_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strm_pause |-> !st_valid);

    // R3: the end marker only rides on a valid beat
    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_last |-> st_valid);

    // R9: busy ends together with the done pulse
    assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9: done lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no beat while idle
    assert_idle_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !st_valid);

    // R7: in-flight reads never exceed the hard cap
    assert_outst_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= OUT_W'(MAX_OUT + 1));

    // R8: buffer plus in-flight never exceed the buffer size
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((LVL_W+1)'(fifo_level) + (LVL_W+1)'(outst)) <= (LVL_W+1)'(DEPTH));

endmodule

bind m2s_read_dma m2s_dma_checker #(
    .DEPTH   (DEPTH),
    .MAX_OUT (MAX_OUT)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mreq_valid (mreq_valid),
    .st_valid   (st_valid),
    .st_last    (st_last),
    .busy       (busy),
    .done       (done),
    .mem_pause  (mem_pause_w),
    .strm_pause (strm_pause_w),
    .outst      (issue_outst),
    .fifo_level (fifo_level)
);

// File: tb/test_m2s_read_dma.sv
module test_m2s_read_dma;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 12;
    localparam int NROWS      = 6;

    typedef struct packed {
        logic [15:0] n;
        logic        last_en;
        logic        swap;
        logic        fixed;
        logic [3:0]  mo;
        logic [31:0] lo;
        logic [31:0] hi;
        logic        mem_tog;
        logic        st_tog;
    } row_t;

    localparam row_t ROWS [NROWS] = '{
        '{16'd5,   1'b1, 1'b0, 1'b0, 4'd8,  32'h1000_0000, 32'h0000_0000, 1'b0, 1'b0},
        '{16'd20,  1'b0, 1'b1, 1'b0, 4'd2,  32'hFFFF_FFF0, 32'h0000_0001, 1'b1, 1'b1},
        '{16'd9,   1'b1, 1'b0, 1'b1, 4'd0,  32'h2000_0044, 32'h0000_00AB, 1'b0, 1'b0},
        '{16'd1,   1'b1, 1'b1, 1'b0, 4'd8,  32'h3000_0003, 32'h0000_0000, 1'b0, 1'b0},
        '{16'd40,  1'b1, 1'b0, 1'b0, 4'd15, 32'h0800_0100, 32'h0000_0000, 1'b0, 1'b0},
        '{16'd200, 1'b0, 1'b0, 1'b0, 4'd8,  32'h0900_0000, 32'h0000_0002, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mreq_valid;
    logic        mreq_ready = 1'b0;
    logic [63:0] mreq_addr;
    logic        mrsp_valid = 1'b0;
    logic [31:0] mrsp_data = '0;
    logic        st_valid;
    logic        st_ready = 1'b0;
    logic [31:0] st_data;
    logic        st_last;
    logic        busy;
    logic        done;

    int errors = 0, checks = 0;
    int fires = 0, inflight = 0, peak = 0, beat = 0, done_cnt = 0, cyc = 0;
    bit mem_tog = 0, st_tog = 0, finished = 0;
    logic [63:0] cur_base = '0;
    bit cur_fixed = 0, cur_swap = 0, cur_last = 0;
    int cur_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    m2s_read_dma i_m2s_read_dma (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .mreq_valid, .mreq_ready, .mreq_addr, .mrsp_valid, .mrsp_data,
        .st_valid, .st_ready, .st_data, .st_last, .busy, .done
    );

    function automatic logic [31:0] mdata(input logic [63:0] a);
        return ((a[31:0] ^ (a[63:32] << 7)) * 32'h9E37_79B1) + 32'h0F1E_2D3C;
    endfunction

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] exp_sum(input logic [63:0] base, input int n, input bit fx);
        logic [31:0] s = '0;
        for (int k = 0; k < n; k++) s += mdata(fx ? base : base + 64'(k) * 64'd4);
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // memory model and stream consumer
    logic        pv [LAT];
    logic [63:0] pa [LAT];
    initial begin
        for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pa[i] = '0; end
        forever begin
            @(negedge clk);
            cyc++;
            mrsp_valid = pv[LAT-1];
            mrsp_data  = mdata(pa[LAT-1]);
            if (pv[LAT-1]) inflight--;
            for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pa[i] = pa[i-1]; end
            mreq_ready = mem_tog ? cyc[0] : 1'b1;
            st_ready   = st_tog ? (cyc % 3 != 0) : 1'b1;
            #1;
            pv[0] = mreq_valid && mreq_ready && rst_n;
            pa[0] = mreq_addr;
            if (pv[0]) begin
                fires++;
                inflight++;
                if (inflight > peak) peak = inflight;
            end
            if (st_valid && st_ready) begin
                logic [63:0] a;
                logic [31:0] w;
                a = cur_fixed ? cur_base : cur_base + 64'(beat) * 64'd4;
                w = cur_swap ? rev(mdata(a)) : mdata(a);
                chk(st_data == w, "R1/R2/R10 stream word", st_data, w);
                chk(st_last == (cur_last && beat == cur_n - 1), "R3 last flag",
                    st_last, (cur_last && beat == cur_n - 1));
                beat++;
            end
            if (done) done_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog R9 completion", 0, 1);
        finish_run();
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2;
        d = reg_rdata;
    endtask

    task automatic start_xfer(input logic [31:0] lo, input logic [31:0] hi, input int n,
                              input bit last, input bit sw, input bit fx);
        cur_base = {hi, lo[31:2], 2'b00};
        cur_n = n; cur_last = last; cur_swap = sw; cur_fixed = fx;
        beat = 0; fires = 0; peak = 0;
        wr(3'd0, lo);
        wr(3'd1, hi);
        wr(3'd2, {n[29:0], 1'b0, last});
    endtask

    task automatic wait_done(input int d0);
        int t = 0;
        while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [31:0] sa;
        int d0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R12 reset state
        #2;
        chk(!busy && !st_valid && !mreq_valid && !done, "R12 idle outputs",
            {busy, st_valid, mreq_valid, done}, 0);
        rd(3'd2, r); chk(r == 0, "R12 size reg", r, 0);
        rd(3'd3, r); chk(r == 0, "R12 ctrl reg", r, 0);
        rd(3'd4, r); chk(r == 0, "R12 status reg", r, 0);
        rd(3'd5, r); chk(r == 0, "R12 checksum reg", r, 0);

        // vector table
        for (int i = 0; i < NROWS; i++) begin
            row_t v;
            int me;
            v = ROWS[i];
            me = (v.mo > 8) ? 8 : int'(v.mo);
            mem_tog = v.mem_tog; st_tog = v.st_tog;
            wr(3'd5, 32'h0);
            wr(3'd3, {24'h0, v.mo, v.fixed, v.swap, 2'b00});
            d0 = done_cnt;
            start_xfer(v.lo, v.hi, int'(v.n), v.last_en, v.swap, v.fixed);
            wait_done(d0);
            chk(beat == int'(v.n), "R1 beat count", beat, v.n);
            chk(done_cnt == d0 + 1, "R9 one done pulse", done_cnt - d0, 1);
            rd(3'd4, r); chk(r == 0, "R9 idle after done", r, 0);
            rd(3'd5, r);
            sa = exp_sum(cur_base, int'(v.n), v.fixed);
            chk(r == sa, "R6 checksum", r, sa);
            chk(peak <= me + 1, "R7 in-flight cap", peak, me + 1);
            if (!v.mem_tog) begin
                int ep;
                ep = (int'(v.n) < me + 1) ? int'(v.n) : me + 1;
                chk(peak == ep, "R7 in-flight peak", peak, ep);
            end
        end
        mem_tog = 0; st_tog = 0;

        // R4 memory pause, R11 readback while busy
        wr(3'd3, 32'h81);
        d0 = done_cnt;
        start_xfer(32'h4000_0000, 32'h0000_0007, 10, 1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(fires == 0, "R4 no request while paused", fires, 0);
        rd(3'd0, r); chk(r == 32'h4000_0000, "R11 address low readback", r, 32'h4000_0000);
        rd(3'd1, r); chk(r == 32'h7, "R11 address high readback", r, 32'h7);
        rd(3'd2, r); chk(r == 32'h29, "R11 size readback", r, 32'h29);
        rd(3'd4, r); chk(r == 1, "R9 busy while paused", r, 1);
        wr(3'd3, 32'h80);
        wait_done(d0);
        chk(beat == 10, "R4 resumed transfer complete", beat, 10);

        // R5 stream pause and R8 room reservation
        wr(3'd5, 32'h0);
        wr(3'd3, 32'h82);
        d0 = done_cnt;
        start_xfer(32'h5000_0000, 32'h0, 150, 1'b1, 1'b0, 1'b0);
        repeat (400) @(negedge clk);
        chk(fires == 128, "R8 reads stop at buffer size", fires, 128);
        #2;
        chk(!st_valid && beat == 0, "R5 no beat while paused", {st_valid, beat[7:0]}, 0);
        rd(3'd2, r); chk(r == ((150 << 2) | 1), "R11 remaining while stalled", r, (150 << 2) | 1);
        wr(3'd3, 32'h80);
        wait_done(d0);
        chk(beat == 150, "R5 resumed with no loss", beat, 150);
        rd(3'd5, r); sa = exp_sum(cur_base, 150, 1'b0);
        chk(r == sa, "R6 checksum after stall", r, sa);

        // R1 size write while busy ignored, R4 resume of unpaused is a no-op
        mem_tog = 1;
        d0 = done_cnt;
        start_xfer(32'h6000_0000, 32'h0, 30, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        wr(3'd2, (7 << 2) | 1);
        wr(3'd3, 32'h80);
        wait_done(d0);
        chk(beat == 30, "R1 busy size write ignored", beat, 30);
        repeat (50) @(negedge clk);
        chk(done_cnt == d0 + 1 && fires == 30, "R1 no second transfer", fires, 30);
        mem_tog = 0;

        // R6 accumulation across transfers and clear
        wr(3'd5, 32'h0);
        d0 = done_cnt;
        start_xfer(32'h7000_0000, 32'h0, 3, 1'b0, 1'b0, 1'b0);
        wait_done(d0);
        d0 = done_cnt;
        start_xfer(32'h7100_0000, 32'h0, 4, 1'b1, 1'b0, 1'b0);
        wait_done(d0);
        sa = exp_sum(64'h7000_0000, 3, 1'b0) + exp_sum(64'h7100_0000, 4, 1'b0);
        rd(3'd5, r); chk(r == sa, "R6 sum carries over", r, sa);
        wr(3'd5, 32'h1);
        rd(3'd5, r); chk(r == 0, "R6 clear", r, 0);

        // R1 zero-length start ignored
        fires = 0;
        wr(3'd2, 32'h1);
        repeat (10) @(negedge clk);
        rd(3'd4, r); chk(r == 0 && fires == 0, "R1 zero size ignored", r, 0);

        finish_run();
    end

endmodule